// File: doc/BRIEF.md
# Phase-Accumulator Waveform Source with Deferred Reconfiguration

This block produces one signed 16-bit sample for each sample-enable strobe. A 32-bit phase accumulator advances by an unsigned frequency word on every strobe. The accumulator value, read as a signed phase, drives one of three shapes: a cosine from a quarter-wave table, a square wave, or a triangle wave. Each raw shape value is scaled by a signed 16-bit amplitude. The square and triangle shapes move their transition point with a signed 32-bit asymmetry threshold.

A host loads a new setting (shape, amplitude, asymmetry and frequency word) through a one-cycle write strobe. The setting is held in a pending slot and does not take effect at once. It becomes active only on a sample where the accumulator addition carries out of bit 31, and the phase restarts at zero on that sample, so no period already under way is cut short. If the active frequency word is zero, the accumulator never wraps, so a pending setting is taken on the very next sample instead.

Top module: `dds_wavegen`

## Requirements
- R1: After reset, sample_out is 0 and sample_valid is 0. The active amplitude is 0, so any sample taken before the first write is 0.
- R2: sample_valid is high in exactly the cycle after a cycle with sample_en high. Without sample_en, sample_out and the phase keep their values.
- R3: Each sample adds the active frequency word to the phase modulo 2^32, and the emitted sample is computed from that updated phase.
- R4: A pending setting becomes active only on a sample whose addition carries out of bit 31. On that sample the phase is 0 and the new setting already shapes the output.
- R5: While the active frequency word is 0, a pending setting becomes active on the next sample, with the phase at 0.
- R6: A second write before activation replaces the first pending setting. A write in the same cycle as an activation stays pending for the next activation.
- R7: Shape code 1 (square): the raw value is +32767 when the signed phase is below the signed asymmetry threshold, and -32768 otherwise.
- R8: Shape code 0 (cosine): the raw value is 32767·cos(2π·phase/2^32), within 500 LSB after scaling.
- R9: Shape code 2 (triangle). Let u = phase XOR 0x8000_0000 and t = threshold XOR 0x8000_0000. When u < t, raw = -32768 + floor(u·65535/t). Otherwise raw = 32767 - floor((u-t)·65535/(2^32-t)).
- R10: The sample is the low 16 bits of (raw × amplitude) shifted right arithmetically by 15. A raw value of -32768 with an amplitude of -32768 therefore gives -32768.
- R11: Shape code 3 gives a raw value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_en | input | 1 | Advance the phase and produce one sample |
| cfg_valid | input | 1 | Load the cfg_* fields into the pending slot |
| cfg_shape | input | 2 | Shape code: 0 cosine, 1 square, 2 triangle, 3 silent |
| cfg_amp | input | 16 | Signed amplitude |
| cfg_asym | input | 32 | Signed asymmetry threshold |
| cfg_freq | input | 32 | Unsigned phase increment per sample |
| sample_out | output | 16 | Signed scaled sample, registered |
| sample_valid | output | 1 | High one cycle after sample_en |

## Verification
The bench writes settings partway through a period and checks each sample against its own phase model. A design that applied settings at once would show the new shape too early. A design that failed to clear the phase would start the new period at the wrong point. The bench loads a zero frequency word to confirm that a stalled generator still takes updates, since without that rule the output would stay frozen. It also writes twice before a wrap, and writes on the exact wrap sample, to catch a design that applies a stale setting or loses the late one. Triangle sweeps with thresholds at the centre, off-centre and at the extreme expose slope and rounding errors. Square sweeps with the most negative amplitude expose a scaler that saturates instead of wrapping.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int PHASE_W  = 32;
  localparam int SAMPLE_W = 16;

  typedef enum logic [1:0] {
    SHP_COS = 2'd0,
    SHP_SQR = 2'd1,
    SHP_TRI = 2'd2,
    SHP_OFF = 2'd3
  } shape_e;

  typedef struct packed {
    shape_e                      shape;
    logic signed [SAMPLE_W-1:0]  amp;
    logic signed [PHASE_W-1:0]   asym;
    logic        [PHASE_W-1:0]   freq;
  } wave_cfg_t;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic               apply,
  input  logic [PHASE_W-1:0] freq,
  output logic [PHASE_W-1:0] phase_q,
  output logic [PHASE_W-1:0] phase_d,
  output logic               carry
);
  logic [PHASE_W-1:0] sum;

  always_comb begin
    {carry, sum} = {1'b0, phase_q} + {1'b0, freq};
    if (apply)
      phase_d = '0;
    else if (sample_en)
      phase_d = sum;
    else
      phase_d = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else if (sample_en)
      phase_q <= phase_d;
  end
endmodule

// File: rtl/dds_cfg_hold.sv
module dds_cfg_hold
  import dds_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sample_en,
  input  logic      cfg_valid,
  input  wave_cfg_t cfg_in,
  input  logic      carry,
  output wave_cfg_t act_q,
  output wave_cfg_t act_d,
  output logic      pend_q,
  output logic      apply
);
  wave_cfg_t pcfg_q, pcfg_d;
  logic      pend_d;
  logic      stalled;

  always_comb begin
    stalled = (act_q.freq == '0);
    apply   = sample_en && pend_q && (carry || stalled);
    act_d   = apply ? pcfg_q : act_q;
    pcfg_d  = cfg_valid ? cfg_in : pcfg_q;
    if (cfg_valid)
      pend_d = 1'b1;
    else if (apply)
      pend_d = 1'b0;
    else
      pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '{shape: SHP_COS, amp: '0, asym: '0, freq: '0};
      pcfg_q <= '{shape: SHP_COS, amp: '0, asym: '0, freq: '0};
      pend_q <= 1'b0;
    end else begin
      if (apply)
        act_q <= act_d;
      if (cfg_valid)
        pcfg_q <= pcfg_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/dds_shape.sv
module dds_shape
  import dds_pkg::*;
#(
  parameter int LUT_BITS = 6
) (
  input  logic [PHASE_W-1:0]         phase,
  input  wave_cfg_t                  cfg,
  output logic signed [SAMPLE_W-1:0] raw
);
  localparam int DEPTH = 1 << LUT_BITS;
  localparam int WW    = 2 * PHASE_W;
  localparam int MAXV  = (1 << (SAMPLE_W - 1)) - 1;
  localparam int MINV  = -(1 << (SAMPLE_W - 1));
  localparam logic [WW-1:0] SPAN  = WW'((64'd1 << SAMPLE_W) - 64'd1);
  localparam logic [WW-1:0] WRAP  = WW'(64'd1 << PHASE_W);
  localparam logic [PHASE_W-1:0] MSB = PHASE_W'(64'd1 << (PHASE_W - 1));

  function automatic logic signed [SAMPLE_W-1:0] cos_entry(input int k);
    real x, x2, c;
    x  = (real'(k) + 0.5) * (3.14159265358979 / 2.0) / real'(DEPTH);
    x2 = x * x;
    c  = 1.0 - x2 / 2.0 + x2 * x2 / 24.0 - x2 * x2 * x2 / 720.0
         + x2 * x2 * x2 * x2 / 40320.0;
    return SAMPLE_W'(int'(c * real'(MAXV)));
  endfunction

  logic signed [SAMPLE_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = cos_entry(g);
  end

  logic [1:0]                 quad;
  logic [LUT_BITS-1:0]        idx;
  logic signed [SAMPLE_W-1:0] cos_v, sqr_v, tri_v;
  logic [WW-1:0]              u, t, num, den, quo;
  logic                       rising;

  always_comb begin
    quad = phase[PHASE_W-1 -: 2];
    idx  = phase[PHASE_W-3 -: LUT_BITS];
    case (quad)
      2'd0:    cos_v =  rom[idx];
      2'd1:    cos_v = -rom[~idx];
      2'd2:    cos_v = -rom[idx];
      default: cos_v =  rom[~idx];
    endcase
  end

  always_comb begin
    sqr_v = ($signed(phase) < cfg.asym) ? SAMPLE_W'(MAXV) : SAMPLE_W'(MINV);
  end

  always_comb begin
    u      = WW'(phase ^ MSB);
    t      = WW'(cfg.asym ^ MSB);
    rising = (u < t);
    if (rising) begin
      num = u * SPAN;
      den = t;
    end else begin
      num = (u - t) * SPAN;
      den = WRAP - t;
    end
    quo = num / den;
    if (rising)
      tri_v = SAMPLE_W'(32'(quo) + MINV);
    else
      tri_v = SAMPLE_W'(MAXV - 32'(quo));
  end

  always_comb begin
    case (cfg.shape)
      SHP_COS: raw = cos_v;
      SHP_SQR: raw = sqr_v;
      SHP_TRI: raw = tri_v;
      default: raw = '0;
    endcase
  end
endmodule

// File: rtl/dds_wavegen.sv
module dds_wavegen
  import dds_pkg::*;
#(
  parameter int LUT_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                cfg_valid,
  input  logic [1:0]          cfg_shape,
  input  logic [SAMPLE_W-1:0] cfg_amp,
  input  logic [PHASE_W-1:0]  cfg_asym,
  input  logic [PHASE_W-1:0]  cfg_freq,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                sample_valid
);
  localparam int PW = 2 * SAMPLE_W;

  wave_cfg_t                  cfg_in, act_q, act_d;
  logic                       pend_q, apply, carry;
  logic [PHASE_W-1:0]         phase_q, phase_d;
  logic signed [SAMPLE_W-1:0] raw;
  logic signed [PW-1:0]       prod, shifted;
  logic [SAMPLE_W-1:0]        sample_d;

  always_comb begin
    cfg_in.shape = shape_e'(cfg_shape);
    cfg_in.amp   = cfg_amp;
    cfg_in.asym  = cfg_asym;
    cfg_in.freq  = cfg_freq;
  end

  dds_cfg_hold u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .cfg_valid (cfg_valid),
    .cfg_in    (cfg_in),
    .carry     (carry),
    .act_q     (act_q),
    .act_d     (act_d),
    .pend_q    (pend_q),
    .apply     (apply)
  );

  dds_phase_acc u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .apply     (apply),
    .freq      (act_q.freq),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .carry     (carry)
  );

  dds_shape #(.LUT_BITS(LUT_BITS)) u_shape (
    .phase (phase_d),
    .cfg   (act_d),
    .raw   (raw)
  );

  always_comb begin
    prod     = PW'(raw) * PW'(act_d.amp);
    shifted  = prod >>> (SAMPLE_W - 1);
    sample_d = shifted[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_out   <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= sample_en;
      if (sample_en)
        sample_out <= sample_d;
    end
  end
endmodule

// File: rtl/dds_wavegen_chk.sv
module dds_wavegen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_en,
  input logic        sample_valid,
  input logic [15:0] sample_out,
  input logic [31:0] phase_q,
  input logic [31:0] act_freq,
  input logic        pend_q,
  input logic        apply
);
  p_valid_follows_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> sample_valid);
  p_valid_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> !sample_valid);
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(sample_out));
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(phase_q));
  p_apply_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> (pend_q && sample_en));
  p_apply_zero_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (phase_q == 32'd0));
  p_stalled_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && act_freq == 32'd0 && !pend_q) |=> $stable(phase_q));
endmodule

bind dds_wavegen dds_wavegen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_en    (sample_en),
  .sample_valid (sample_valid),
  .sample_out   (sample_out),
  .phase_q      (phase_q),
  .act_freq     (act_q.freq),
  .pend_q       (pend_q),
  .apply        (apply)
);

// File: tb/tb_dds_wavegen.sv
module tb_dds_wavegen;
  import dds_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_shape = '0;
  logic [15:0] cfg_amp = '0;
  logic [31:0] cfg_asym = '0;
  logic [31:0] cfg_freq = '0;
  logic [15:0] sample_out;
  logic        sample_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dds_wavegen dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .cfg_valid(cfg_valid),
    .cfg_shape(cfg_shape), .cfg_amp(cfg_amp), .cfg_asym(cfg_asym),
    .cfg_freq(cfg_freq), .sample_out(sample_out), .sample_valid(sample_valid)
  );

  // reference state
  logic [31:0] m_phase;
  wave_cfg_t   m_act, m_pcfg;
  bit          m_pend, m_over;

  function automatic wave_cfg_t mk(input int s, input int a, input int unsigned y,
                                   input int unsigned f);
    wave_cfg_t c;
    c.shape = shape_e'(s[1:0]);
    c.amp   = a[15:0];
    c.asym  = y;
    c.freq  = f;
    return c;
  endfunction

  function automatic int raw_exact(input wave_cfg_t c, input logic [31:0] ph);
    longint u, t, q;
    case (c.shape)
      SHP_SQR: return ($signed(ph) < c.asym) ? 32767 : -32768;
      SHP_TRI: begin
        u = longint'({32'd0, ph ^ 32'h8000_0000});
        t = longint'({32'd0, c.asym ^ 32'h8000_0000});
        if (u < t) begin
          q = (u * 65535) / t;
          return int'(q) - 32768;
        end
        q = ((u - t) * 65535) / (64'd4294967296 - t);
        return 32767 - int'(q);
      end
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input bit ok, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic compare_sample(input string tag);
    logic signed [31:0] p;
    logic signed [15:0] e16;
    real e, d;
    if (m_act.shape == SHP_COS) begin
      e = $cos(2.0 * 3.14159265358979 * real'(m_phase) / 4294967296.0) * 32767.0
          * real'(m_act.amp) / 32768.0;
      d = real'($signed(sample_out)) - e;
      if (d < 0.0) d = -d;
      check(tag, d <= 500.0, int'($signed(sample_out)), int'(e));
    end else begin
      p   = 32'(raw_exact(m_act, m_phase)) * 32'(m_act.amp);
      p   = p >>> 15;
      e16 = p[15:0];
      check(tag, sample_out == e16, int'($signed(sample_out)), int'(e16));
    end
  endtask

  task automatic do_sample(input bit wr, input wave_cfg_t c);
    logic [32:0] sum;
    bit app;
    string tag;
    sample_en = 1'b1;
    cfg_valid = wr;
    cfg_shape = c.shape; cfg_amp = c.amp; cfg_asym = c.asym; cfg_freq = c.freq;
    @(posedge clk);
    sum = {1'b0, m_phase} + {1'b0, m_act.freq};
    app = m_pend && (sum[32] || m_act.freq == 32'd0);
    tag = "";
    if (app) begin
      tag = (m_act.freq == 32'd0) ? "R5" : (m_over ? "R6" : "R4");
      m_act = m_pcfg; m_phase = '0; m_pend = 0; m_over = 0;
    end else begin
      m_phase = sum[31:0];
    end
    if (wr) begin
      m_over = m_pend || app;
      m_pcfg = c;
      m_pend = 1;
    end
    @(negedge clk);
    sample_en = 1'b0;
    cfg_valid = 1'b0;
    if (tag == "") begin
      if (m_act.amp == 16'sh8000) tag = "R10";
      else case (m_act.shape)
        SHP_COS: tag = "R8";
        SHP_SQR: tag = "R7";
        SHP_TRI: tag = "R9";
        default: tag = "R11";
      endcase
    end
    if (!sample_valid) check("R2 valid", 1'b0, 0, 1);
    compare_sample({tag, " R3"});
  endtask

  task automatic do_write(input wave_cfg_t c);
    cfg_valid = 1'b1;
    cfg_shape = c.shape; cfg_amp = c.amp; cfg_asym = c.asym; cfg_freq = c.freq;
    @(negedge clk);
    cfg_valid = 1'b0;
    m_over = m_pend;
    m_pcfg = c;
    m_pend = 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) do_sample(1'b0, '0);
  endtask

  task automatic idle_check(input int n);
    logic [15:0] last;
    last = sample_out;
    repeat (n) @(negedge clk);
    check("R2 idle valid", sample_valid == 1'b0, int'(sample_valid), 0);
    check("R2 idle hold", sample_out == last, int'(sample_out), int'(last));
  endtask

  initial begin
    m_phase = '0;
    m_act = mk(0, 0, 0, 0);
    m_pcfg = m_act;
    m_pend = 0; m_over = 0;
    repeat (3) @(negedge clk);
    check("R1 reset out", sample_out == 16'd0, int'(sample_out), 0);
    check("R1 reset valid", sample_valid == 1'b0, int'(sample_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_sample(1'b0, '0);
    check("R1 zero amp", sample_out == 16'd0, int'(sample_out), 0);
    idle_check(3);

    // cosine sweep, applied at once since active word is zero
    do_write(mk(0, 32767, 0, 32'h0400_0000));
    run(80);
    // square written mid-period: deferred to the wrap
    do_write(mk(1, 32767, 0, 32'h1000_0000));
    run(70);
    // most negative amplitude
    do_write(mk(1, -32768, 32'h3000_0000, 32'h1000_0000));
    run(40);
    do_write(mk(1, -32768, 32'hD000_0000, 32'h1000_0000));
    run(40);
    // triangle sweeps with several thresholds
    do_write(mk(2, 20000, 32'h0000_0000, 32'h0100_0000));
    run(300);
    do_write(mk(2, 32767, 32'h4000_0000, 32'h0100_0000));
    run(300);
    do_write(mk(2, -12345, 32'hA000_0000, 32'h0100_0000));
    run(300);
    do_write(mk(2, 32767, 32'h7FFF_FFFF, 32'h0100_0000));
    run(300);
    // overwrite of a pending setting
    do_write(mk(2, 1000, 0, 32'h0200_0000));
    do_write(mk(1, 30000, 32'h6000_0000, 32'h1000_0000));
    run(300);
    // write on the exact wrap sample
    while (({1'b0, m_phase} + {1'b0, m_act.freq}) < 33'h1_0000_0000) do_sample(1'b0, '0);
    do_sample(1'b1, mk(3, 32767, 0, 32'h2000_0000));
    run(40);
    // stalled generator
    do_write(mk(0, 10000, 0, 32'h0000_0000));
    run(12);
    do_write(mk(1, 32767, 32'h7000_0000, 32'h0800_0000));
    run(40);
    idle_check(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule